// File: doc/BRIEF.md
# Special-Event Dispatcher with Vectored Interrupts

This block decides, for a VLIW-style core, when the fetch stream is taken away from the program and sent to a handler. It only acts in the cycle where the core reports that an interruptible jump has completed. Events are never taken at an arbitrary instruction boundary. When an event is taken, the jump's destination is kept as the saved return address. The fetch address is then redirected to a single exception handler address, or to the handler address programmed for the winning interrupt source. Reset is the one event that acts at any time: while it is asserted, the block steers fetch to a fixed restart address.

Software programs a status word, a pending set, a mask set, the exception handler address and one handler address per interrupt source through a word-addressed register port. Writes take effect in one cycle and read data is registered. The status word carries seven paired flag/enable bits plus one more pair, a trap-force bit and a global interrupt enable. Sources chosen by a parameter are non-maskable by the global enable, but they still obey their mask bit.

Top module: `evt_dispatch`

## Requirements
- R1: While `rst_n` is low, `redir_vld` is 1, `redir_pc` equals parameter `RESET_PC`, `redir_cause` is 0 (reset) and `redir_src` is 0. The status word, pending, mask, exception address, saved address, every vector and the read data are all cleared to zero.
- R2: A redirect appears (`redir_vld` = 1) only in the cycle after a clock edge at which `ij_ok` was 1 and an event qualified. After any other edge, `redir_vld` is 0, `redir_cause` is 3 (none), and `redir_pc` and `redir_src` are 0.
- R3: An exception qualifies when any of the following is 1: `psw[k] & psw[16+k]` for k in 0..6, `psw[15] & psw[31]`, or the trap-force bit `psw[11]`. It beats every interrupt. The redirect then carries cause 1, the exception address register, and source 0.
- R4: Interrupt source i is eligible when pending[i] and mask[i] are both 1 and either bit i of parameter `NMI_SRC` is 1 or the global enable `psw[10]` is 1. With no exception and at least one eligible source, `ij_ok` gives cause 2, `redir_src` = the source, and `redir_pc` = that source's vector.
- R5: Among eligible sources, the lowest index wins.
- R6: On every exception or interrupt dispatch, the saved address (`saved_pc`) takes the value of `ij_target`. It keeps its value at all other times, and bus writes to it are ignored.
- R7: A pending bit is set at any edge where its `irq_req` input is 1, and it then stays set. Writing 1 to it clears it, unless its request is 1 at the same edge. Writing 0 has no effect. A dispatch does not clear it.
- R8: Word addresses are: status 0x40200, pending 0x40201, mask 0x40202, exception address 0x40203, saved address 0x40204 (read-only), and vector n at 0x40220+n. A write lands at the edge it is presented. `bus_rdata` shows, one cycle after `bus_addr`, the register value as it was before any write at that same edge.
- R9: Unmapped addresses read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, the highest-priority event |
| irq_req | input | NSRC | Level interrupt requests |
| ij_ok | input | 1 | An interruptible jump succeeded this cycle |
| ij_target | input | DW | Destination of that jump |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 20 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| redir_vld | output | 1 | Fetch redirect request |
| redir_pc | output | DW | Redirect address |
| redir_cause | output | 2 | 0 reset, 1 exception, 2 interrupt, 3 none |
| redir_src | output | IW | Winning interrupt source |
| saved_pc | output | DW | Saved return address |

## Verification
On every cycle, the assertions check these rules: no redirect appears without a completed jump; an exception takes precedence and uses its own handler address; an interrupt redirect carries the chosen source and that source's vector; no lower-numbered eligible source is passed over; the saved address follows the jump target on dispatch; and pending bits are sticky and clear on a one-write. The status-word pairing, the non-maskable bypass, the register map, and the zero reads from unmapped addresses only become visible through the bench's scenarios. The same holds for reset applied mid-stream and a write colliding with a dispatch. In those scenarios, the behavioural model predicts every output on every clock.

// File: rtl/evd_pkg.sv
package evd_pkg;
   localparam int BUS_AW = 20;
   localparam logic [BUS_AW-1:0] A_PSW  = 20'h40200;
   localparam logic [BUS_AW-1:0] A_PEND = 20'h40201;
   localparam logic [BUS_AW-1:0] A_MASK = 20'h40202;
   localparam logic [BUS_AW-1:0] A_EXCV = 20'h40203;
   localparam logic [BUS_AW-1:0] A_DPC  = 20'h40204;
   localparam logic [BUS_AW-1:0] A_VEC0 = 20'h40220;
   localparam int PSW_IEN = 10;
   localparam int PSW_TFE = 11;
   typedef enum logic [1:0] {
      CAUSE_RST  = 2'd0,
      CAUSE_EXC  = 2'd1,
      CAUSE_INT  = 2'd2,
      CAUSE_NONE = 2'd3
   } cause_e;
endpackage

// File: rtl/evd_regs.sv
module evd_regs
   import evd_pkg::*;
#(
   parameter int NSRC = 32,
   parameter int DW   = 32,
   localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              dpc_ld,
   input  logic [DW-1:0]     dpc_val,
   output logic [31:0]       psw,
   output logic [NSRC-1:0]   pend,
   output logic [NSRC-1:0]   mask,
   output logic [DW-1:0]     excvec,
   output logic [DW-1:0]     dpc,
   output logic [DW-1:0]     vec [NSRC],
   output logic [DW-1:0]     bus_rdata
);
   logic [BUS_AW-1:0] voff;
   logic              vhit;
   logic [NSRC-1:0]   clr;
   logic [DW-1:0]     rd_next;

   assign voff = bus_addr - A_VEC0;
   assign vhit = (bus_addr >= A_VEC0) && (voff < BUS_AW'(NSRC));
   assign clr  = (bus_we && bus_addr == A_PEND) ? bus_wdata[NSRC-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psw    <= '0;
         pend   <= '0;
         mask   <= '0;
         excvec <= '0;
         dpc    <= '0;
      end else begin
         if (bus_we && bus_addr == A_PSW)  psw    <= bus_wdata[31:0];
         if (bus_we && bus_addr == A_MASK) mask   <= bus_wdata[NSRC-1:0];
         if (bus_we && bus_addr == A_EXCV) excvec <= bus_wdata;
         if (dpc_ld)                       dpc    <= dpc_val;
         pend <= (pend & ~clr) | irq_req;
      end
   end

   for (genvar g = 0; g < NSRC; g++) begin : g_vec
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            vec[g] <= '0;
         else if (bus_we && vhit && voff[IW-1:0] == IW'(g))
            vec[g] <= bus_wdata;
      end
   end

   always_comb begin
      rd_next = '0;
      if (vhit) rd_next = vec[voff[IW-1:0]];
      else begin
         case (bus_addr)
            A_PSW:   rd_next = DW'(psw);
            A_PEND:  rd_next = DW'(pend);
            A_MASK:  rd_next = DW'(mask);
            A_EXCV:  rd_next = excvec;
            A_DPC:   rd_next = dpc;
            default: rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

   // R7
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pend & $past(irq_req)) == $past(irq_req)));
   // R7
   pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_PEND) |=>
         ((pend & $past(bus_wdata[NSRC-1:0] & ~irq_req)) == '0));
endmodule

// File: rtl/evd_qual.sv
module evd_qual
   import evd_pkg::*;
#(
   parameter int            NSRC    = 32,
   parameter logic [NSRC-1:0] NMI_SRC = '0
) (
   input  logic [31:0]     psw,
   input  logic [NSRC-1:0] pend,
   input  logic [NSRC-1:0] mask,
   output logic            exc_hit,
   output logic [NSRC-1:0] cand
);
   logic [7:0] flags, enables;
   logic       unused_psw_bits;

   assign flags   = {psw[15], psw[6:0]};
   assign enables = {psw[31], psw[22:16]};
   assign exc_hit = (|(flags & enables)) | psw[PSW_TFE];
   assign cand    = pend & mask & (NMI_SRC | {NSRC{psw[PSW_IEN]}});
   assign unused_psw_bits = ^{psw[30:23], psw[14:12], psw[9:7]};
endmodule

// File: rtl/evd_pick.sv
module evd_pick #(
   parameter int N         = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IW       = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   assign any = |req;

   if (LOW_FIRST) begin : g_low
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req[i]) idx = IW'(i);
      end
   end else begin : g_high
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++)
            if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/evt_dispatch.sv
module evt_dispatch
   import evd_pkg::*;
#(
   parameter int              NSRC      = 32,
   parameter int              DW        = 32,
   parameter logic [NSRC-1:0] NMI_SRC   = 32'h0000_0003,
   parameter logic [DW-1:0]   RESET_PC  = 32'h0000_1000,
   parameter bit              LOW_FIRST = 1'b1,
   localparam int             IW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   irq_req,
   input  logic              ij_ok,
   input  logic [DW-1:0]     ij_target,
   input  logic              bus_we,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic              redir_vld,
   output logic [DW-1:0]     redir_pc,
   output logic [1:0]        redir_cause,
   output logic [IW-1:0]     redir_src,
   output logic [DW-1:0]     saved_pc
);
   if (NSRC < 2 || NSRC > 32) begin : g_bad_nsrc
      $error("evt_dispatch: NSRC must lie in 2..32");
   end
   if (DW < 32) begin : g_bad_dw
      $error("evt_dispatch: DW must be at least 32");
   end

   logic [31:0]     psw;
   logic [NSRC-1:0] pend, mask, cand;
   logic [DW-1:0]   excvec;
   logic [DW-1:0]   vec [NSRC];
   logic            exc_hit, cand_any, dpc_ld;
   logic [IW-1:0]   win_idx;
   logic [DW-1:0]   win_vec;

   evd_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .irq_req(irq_req), .dpc_ld(dpc_ld),
      .dpc_val(ij_target), .psw(psw), .pend(pend), .mask(mask),
      .excvec(excvec), .dpc(saved_pc), .vec(vec), .bus_rdata(bus_rdata)
   );

   evd_qual #(.NSRC(NSRC), .NMI_SRC(NMI_SRC)) u_qual (
      .psw(psw), .pend(pend), .mask(mask), .exc_hit(exc_hit), .cand(cand)
   );

   evd_pick #(.N(NSRC), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req(cand), .any(cand_any), .idx(win_idx)
   );

   assign win_vec = vec[win_idx];
   assign dpc_ld  = ij_ok && (exc_hit || cand_any);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redir_vld   <= 1'b1;
         redir_pc    <= RESET_PC;
         redir_cause <= CAUSE_RST;
         redir_src   <= '0;
      end else if (ij_ok && exc_hit) begin
         redir_vld   <= 1'b1;
         redir_pc    <= excvec;
         redir_cause <= CAUSE_EXC;
         redir_src   <= '0;
      end else if (ij_ok && cand_any) begin
         redir_vld   <= 1'b1;
         redir_pc    <= win_vec;
         redir_cause <= CAUSE_INT;
         redir_src   <= win_idx;
      end else begin
         redir_vld   <= 1'b0;
         redir_pc    <= '0;
         redir_cause <= CAUSE_NONE;
         redir_src   <= '0;
      end
   end

   // R2
   no_stray_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ij_ok |=> (!redir_vld && redir_cause == CAUSE_NONE));
   // R3
   exc_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ij_ok && exc_hit) |=>
         (redir_vld && redir_cause == CAUSE_EXC && redir_pc == $past(excvec)));
   // R4
   int_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ij_ok && !exc_hit && cand_any) |=>
         (redir_vld && redir_cause == CAUSE_INT && redir_src == $past(win_idx)
          && redir_pc == $past(win_vec)));
   // R6
   dpc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dpc_ld |=> (saved_pc == $past(ij_target)));
   // R6
   dpc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dpc_ld |=> $stable(saved_pc));

   if (LOW_FIRST) begin : g_low_chk
      // R5
      low_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cand_any |-> ((cand & ~({NSRC{1'b1}} << win_idx)) == '0 && cand[win_idx]));
   end
endmodule

// File: tb/tb_evt_dispatch.sv
module tb_evt_dispatch;
   import evd_pkg::*;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 32;
   localparam int DW = 32;
   localparam logic [31:0] NMI = 32'h0000_0003;
   localparam logic [31:0] RPC = 32'h0000_1000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   irq_req = '0;
   logic              ij_ok = 1'b0;
   logic [DW-1:0]     ij_target = '0;
   logic              bus_we = 1'b0;
   logic [BUS_AW-1:0] bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0;
   logic [DW-1:0]     bus_rdata, redir_pc, saved_pc;
   logic              redir_vld;
   logic [1:0]        redir_cause;
   logic [4:0]        redir_src;

   evt_dispatch #(.NSRC(NSRC), .DW(DW), .NMI_SRC(NMI), .RESET_PC(RPC)) dut (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .ij_ok(ij_ok),
      .ij_target(ij_target), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .redir_vld(redir_vld),
      .redir_pc(redir_pc), .redir_cause(redir_cause), .redir_src(redir_src),
      .saved_pc(saved_pc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   logic [31:0] m_psw = 0, m_pend = 0, m_mask = 0, m_exc = 0, m_dpc = 0, m_rd = 0, m_pc = RPC;
   logic [31:0] m_vec [32];
   logic        m_vld = 1'b1;
   logic [1:0]  m_cause = 2'd0;
   logic [4:0]  m_src = 0;
   logic [19:0] m_last_addr = 0;
   int n_chk = 0, n_fail = 0;
   bit timed_out = 0;

   initial for (int i = 0; i < 32; i++) m_vec[i] = 0;

   function automatic logic [31:0] mread(input logic [19:0] a);
      if (a == A_PSW)  return m_psw;
      if (a == A_PEND) return m_pend;
      if (a == A_MASK) return m_mask;
      if (a == A_EXCV) return m_exc;
      if (a == A_DPC)  return m_dpc;
      if (a >= A_VEC0 && a < A_VEC0 + 20'd32) return m_vec[a - A_VEC0];
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_psw = 0; m_pend = 0; m_mask = 0; m_exc = 0; m_dpc = 0; m_rd = 0;
         for (int i = 0; i < 32; i++) m_vec[i] = 0;
         m_vld = 1; m_pc = RPC; m_cause = 0; m_src = 0; m_last_addr = 0;
      end else begin
         bit exc;
         int win;
         logic [31:0] clrv;
         exc = m_psw[11] || (m_psw[15] && m_psw[31]);
         for (int k = 0; k < 7; k++) if (m_psw[k] && m_psw[16+k]) exc = 1;
         win = -1;
         for (int i = 0; i < 32; i++)
            if (win < 0 && m_pend[i] && m_mask[i] && (NMI[i] || m_psw[10])) win = i;
         m_rd = mread(bus_addr);
         m_last_addr = bus_addr;
         if (ij_ok && exc) begin
            m_vld = 1; m_pc = m_exc; m_cause = 1; m_src = 0; m_dpc = ij_target;
         end else if (ij_ok && win >= 0) begin
            m_vld = 1; m_pc = m_vec[win]; m_cause = 2; m_src = 5'(win); m_dpc = ij_target;
         end else begin
            m_vld = 0; m_pc = 0; m_cause = 3; m_src = 0;
         end
         clrv = 0;
         if (bus_we) begin
            if (bus_addr == A_PSW)  m_psw = bus_wdata;
            if (bus_addr == A_MASK) m_mask = bus_wdata;
            if (bus_addr == A_EXCV) m_exc = bus_wdata;
            if (bus_addr == A_PEND) clrv = bus_wdata;
            if (bus_addr >= A_VEC0 && bus_addr < A_VEC0 + 20'd32) m_vec[bus_addr - A_VEC0] = bus_wdata;
         end
         m_pend = (m_pend & ~clrv) | irq_req;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s at %0t: got %h expected %h", tag, what, $time, got, exp);
      end
   endtask

   always @(negedge clk) begin
      string rt, dt;
      case (m_cause)
         2'd0: rt = "R1";
         2'd1: rt = "R3";
         2'd2: rt = "R4";
         default: rt = "R2";
      endcase
      chk(rt, "redir_vld", 32'(redir_vld), 32'(m_vld));
      chk(rt, "redir_pc", redir_pc, m_pc);
      chk(rt, "redir_cause", 32'(redir_cause), 32'(m_cause));
      chk((m_cause == 2'd2) ? "R5" : rt, "redir_src", 32'(redir_src), 32'(m_src));
      chk(rst_n ? "R6" : "R1", "saved_pc", saved_pc, m_dpc);
      if (m_last_addr == A_PEND) dt = "R7";
      else if (mread(m_last_addr) === 32'h0 && !(m_last_addr >= A_PSW && m_last_addr <= A_DPC)
               && !(m_last_addr >= A_VEC0 && m_last_addr < A_VEC0 + 20'd32)) dt = "R9";
      else dt = "R8";
      chk(dt, "bus_rdata", bus_rdata, m_rd);
   end

   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic wr(input logic [19:0] a, input logic [31:0] d);
      bus_we = 1; bus_addr = a; bus_wdata = d; cyc();
      bus_we = 0;
   endtask

   task automatic jump(input logic [31:0] t);
      ij_ok = 1; ij_target = t; cyc();
      ij_ok = 0;
   endtask

   task automatic run_all();
      repeat (3) cyc();
      rst_n = 1; cyc();
      // R8: program vectors and exception address, read back
      for (int i = 0; i < 32; i++) wr(A_VEC0 + 20'(i), 32'h8000_0000 + 32'(i) * 32'h100);
      wr(A_EXCV, 32'h4000_0000);
      bus_addr = A_VEC0 + 20'd7; cyc();
      bus_addr = A_EXCV; cyc();
      // R9: unmapped read and ignored write
      wr(20'h40210, 32'hDEAD_BEEF);
      bus_addr = 20'h40210; cyc();
      bus_addr = A_VEC0 + 20'd32; cyc();
      // R2: jump with nothing pending
      jump(32'h0000_2000);
      // R4: sources 3 and 5 pending, only 5 unmasked, global enable off
      irq_req = 32'h28; cyc(); irq_req = 0;
      wr(A_MASK, 32'h20);
      jump(32'h0000_2100);
      wr(A_PSW, 32'h400);
      jump(32'h0000_2200);
      // R5: unmask 3, lower index wins
      wr(A_MASK, 32'h28);
      jump(32'h0000_2300);
      // R4: non-maskable source 1 with enable off
      wr(A_PSW, 32'h0);
      irq_req = 32'h2; cyc(); irq_req = 0;
      jump(32'h0000_2400);
      wr(A_MASK, 32'h2A);
      jump(32'h0000_2500);
      // R3: trap-force, paired flag/enable, bit 15/31 pair
      wr(A_PSW, 32'h0000_0C00);
      jump(32'h0000_2600);
      wr(A_PSW, 32'h0001_0001);
      jump(32'h0000_2700);
      wr(A_PSW, 32'h8000_8000);
      jump(32'h0000_2800);
      wr(A_PSW, 32'h0000_0041);
      jump(32'h0000_2900);
      // R7: write-one-clear, and clear against an active request
      bus_addr = A_PEND; cyc();
      wr(A_PEND, 32'h8);
      irq_req = 32'h20; wr(A_PEND, 32'h20); irq_req = 0;
      bus_addr = A_PEND; cyc(); cyc();
      // R6: write to saved address ignored
      wr(A_DPC, 32'h1234_5678);
      bus_addr = A_DPC; cyc(); cyc();
      // random phase with one mid-run reset
      for (int n = 0; n < 4000; n++) begin
         int k;
         if (n == 2000) begin rst_n = 0; cyc(); cyc(); rst_n = 1; end
         irq_req = $urandom & $urandom & $urandom & $urandom;
         ij_ok = ($urandom % 3) == 0;
         ij_target = $urandom;
         bus_we = ($urandom % 3) == 0;
         k = $urandom % 45;
         if (k < 5) bus_addr = A_PSW + 20'(k);
         else if (k < 37) bus_addr = A_VEC0 + 20'(k - 5);
         else bus_addr = 20'($urandom);
         bus_wdata = $urandom;
         if (bus_addr == A_PSW)
            bus_wdata = (($urandom % 4) == 0) ? $urandom : ($urandom & 32'h0000_0400);
         cyc();
      end
      bus_we = 0; ij_ok = 0; irq_req = 0;
      cyc(); cyc();
   endtask

   initial begin
      fork
         run_all();
         begin
            #(CLK_PERIOD * 200000);
            timed_out = 1;
         end
      join_any
      if (timed_out) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule